// File: doc/BRIEF.md
# Cross-Domain Register Write Synchronizer

This block links a register interface that runs on the bus clock to a peripheral core that runs on a second clock with no fixed relation to it. Writes to two registers, a control register and a kick register, must reach the core domain. The block takes such a write, keeps the data in a bus-side holding register, and passes it across with a toggle request and a toggle acknowledge. Each toggle goes through a two-flop synchronizer.

While a transfer is in flight, a busy bit is visible to software and on a port. When the acknowledge returns, a sync-ready flag is set. That flag can raise a single interrupt line, gated by an enable that is changed through separate set and clear registers. A second write to a synchronized register that arrives while busy is 1 is stalled: ready is held low until the block is idle, and the write is then taken in order. All other accesses finish in one bus cycle at any time.

Register map (3-bit address): 0 control (synchronized), 1 kick (synchronized), 2 status (bit 0 busy, read-only), 3 flag (bit 0 sync-ready), 4 enable-set, 5 enable-clear.

Top module: `wsync_bridge`

## Requirements
- R1: After reset: syncBusy=0, irq=0, busReady=1, coreCtrl=0, coreKick=0. The flag bit and the enable bit are 0.
- R2: A write to address 0 is carried to coreCtrl in the core domain. Reading address 0 returns the last accepted control value.
- R3: A write to address 1 gives exactly one one-cycle coreKick pulse, with coreKickVal equal to the written data. coreCtrl is left unchanged.
- R4: Busy (syncBusy, and bit 0 of address 2) reads 1 from the bus cycle after a synchronized write is accepted. It stays 1 until the acknowledge returns, then goes to 0.
- R5: When a transfer completes, bit 0 of address 3 (sync-ready flag) becomes 1.
- R6: A write to address 0 or 1 while busy is 1 sees busReady=0 and has no effect until busy clears. It is then accepted, and the core sees both values in issue order.
- R7: irq is 1 exactly while the flag bit and the enable bit are both 1. It stays 1 until one of them is cleared.
- R8: Writing bit 0 = 1 to address 4 sets the enable, and writing bit 0 = 1 to address 5 clears it. Writing bit 0 = 0 to either has no effect. Reading address 4 or 5 returns the enable in bit 0.
- R9: Writing bit 0 = 1 to address 3 clears the flag, and writing bit 0 = 0 leaves it unchanged.
- R10: Reads of any address, and writes to addresses 2 to 5, complete with busReady=1 even while busy is 1.
- R11: The holding register does not change while a transfer is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Bus-domain clock |
| busRstN | input | 1 | Bus-domain reset, active low |
| coreClk | input | 1 | Core-domain clock |
| coreRstN | input | 1 | Core-domain reset, active low |
| busSel | input | 1 | Access request |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Register address |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data (combinational) |
| busReady | output | 1 | Low = wait state, access not taken |
| syncBusy | output | 1 | Transfer in flight |
| irq | output | 1 | Shared interrupt request |
| coreCtrl | output | DATA_W | Control value in core domain |
| coreKick | output | 1 | One-cycle kick strobe in core domain |
| coreKickVal | output | DATA_W | Data of the last kick |

## Verification
The assertions assume that an access is taken only on a bus edge where busSel and busReady are both 1. They also assume the address, data and direction stay constant through a stall, and that both resets are asserted together from time zero. The bench drives every access on the falling edge and holds it through any wait state until ready is seen. It asserts both resets at the same time, and runs the two clocks at unrelated periods, so that the toggle crossing sees varying phase.

// File: rtl/wsync_pkg.sv
package wsync_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_KICK  = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_FLAG  = 3'd3;
  localparam logic [ADDR_W-1:0] A_ENSET = 3'd4;
  localparam logic [ADDR_W-1:0] A_ENCLR = 3'd5;

  // Strobes from bus control to the crossing datapath
  typedef struct packed {
    logic launch;  // accept a synchronized write this cycle
    logic toKick;  // target is the kick register (else control)
  } xferStrobeT;
endpackage

// File: rtl/wsync_sync2.sv
module wsync_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/wsync_ctrl.sv
module wsync_ctrl
  import wsync_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              busClk,
  input  logic              busRstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] ctrlShadow,
  input  logic              ackDone,
  output xferStrobeT        strobe,
  output logic [DATA_W-1:0] busRdata,
  output logic              busReady,
  output logic              syncBusy,
  output logic              irq
);
  localparam logic [DATA_W-1:0] ZERO = '0;

  logic busy, flag, irqEn;
  logic wrReq, isSync, wrFlag, wrEnSet, wrEnClr;

  assign wrReq   = busSel && busWrite;
  assign isSync  = (busAddr == A_CTRL) || (busAddr == A_KICK);
  assign wrFlag  = wrReq && (busAddr == A_FLAG);
  assign wrEnSet = wrReq && (busAddr == A_ENSET);
  assign wrEnClr = wrReq && (busAddr == A_ENCLR);

  assign busReady      = !(wrReq && isSync && busy);
  assign strobe.launch = wrReq && isSync && !busy;
  assign strobe.toKick = (busAddr == A_KICK);

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      busy  <= 1'b0;
      flag  <= 1'b0;
      irqEn <= 1'b0;
    end else begin
      if (strobe.launch)  busy <= 1'b1;
      else if (ackDone)   busy <= 1'b0;

      if (ackDone)                    flag <= 1'b1;
      else if (wrFlag && busWdata[0]) flag <= 1'b0;

      if (wrEnSet && busWdata[0])      irqEn <= 1'b1;
      else if (wrEnClr && busWdata[0]) irqEn <= 1'b0;
    end
  end

  assign syncBusy = busy;
  assign irq      = flag && irqEn;

  always_comb begin
    busRdata = ZERO;
    unique case (busAddr)
      A_CTRL:          busRdata = ctrlShadow;
      A_STAT:          busRdata = {ZERO[DATA_W-1:1], busy};
      A_FLAG:          busRdata = {ZERO[DATA_W-1:1], flag};
      A_ENSET, A_ENCLR: busRdata = {ZERO[DATA_W-1:1], irqEn};
      default:         busRdata = ZERO;
    endcase
  end

  // R4
  busy_set_chk: assert property (@(posedge busClk) disable iff (!busRstN)
    strobe.launch |=> busy);
  // R5
  flag_on_done_chk: assert property (@(posedge busClk) disable iff (!busRstN)
    ackDone |=> flag);
  // R6
  no_launch_busy_chk: assert property (@(posedge busClk) disable iff (!busRstN)
    busy |-> !strobe.launch);
  // R7
  irq_hold_chk: assert property (@(posedge busClk) disable iff (!busRstN)
    (irq && !(wrFlag && busWdata[0]) && !(wrEnClr && busWdata[0])) |=> irq);
endmodule

// File: rtl/wsync_dpath.sv
module wsync_dpath
  import wsync_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SYNC_STG  = 2
) (
  input  logic              busClk,
  input  logic              busRstN,
  input  logic              coreClk,
  input  logic              coreRstN,
  input  xferStrobeT        strobe,
  input  logic              busyIn,
  input  logic [DATA_W-1:0] busWdata,
  output logic              ackDone,
  output logic [DATA_W-1:0] ctrlShadow,
  output logic [DATA_W-1:0] coreCtrl,
  output logic              coreKick,
  output logic [DATA_W-1:0] coreKickVal
);
  // bus side
  logic [DATA_W-1:0] holdData;
  logic              holdKick, reqTgl, ackSync, ackPrev;
  // core side
  logic reqSync, reqPrev, ackTgl, newReq;

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      holdData   <= '0;
      holdKick   <= 1'b0;
      reqTgl     <= 1'b0;
      ctrlShadow <= '0;
      ackPrev    <= 1'b0;
    end else begin
      ackPrev <= ackSync;
      if (strobe.launch) begin
        holdData <= busWdata;
        holdKick <= strobe.toKick;
        reqTgl   <= ~reqTgl;
        if (!strobe.toKick) ctrlShadow <= busWdata;
      end
    end
  end

  assign ackDone = ackSync ^ ackPrev;

  wsync_sync2 #(.STAGES(SYNC_STG)) reqSync_i (
    .clk(coreClk), .rstN(coreRstN), .d(reqTgl), .q(reqSync));
  wsync_sync2 #(.STAGES(SYNC_STG)) ackSync_i (
    .clk(busClk), .rstN(busRstN), .d(ackTgl), .q(ackSync));

  assign newReq = reqSync ^ reqPrev;

  always_ff @(posedge coreClk or negedge coreRstN) begin
    if (!coreRstN) begin
      reqPrev     <= 1'b0;
      ackTgl      <= 1'b0;
      coreCtrl    <= '0;
      coreKick    <= 1'b0;
      coreKickVal <= '0;
    end else begin
      reqPrev  <= reqSync;
      coreKick <= 1'b0;
      if (newReq) begin
        ackTgl <= reqSync;
        if (holdKick) begin
          coreKick    <= 1'b1;
          coreKickVal <= holdData;
        end else begin
          coreCtrl <= holdData;
        end
      end
    end
  end

  // R11
  hold_stable_chk: assert property (@(posedge busClk) disable iff (!busRstN)
    (busyIn && !strobe.launch) |=> $stable(holdData));
  // R3
  kick_pulse_chk: assert property (@(posedge coreClk) disable iff (!coreRstN)
    coreKick |=> !coreKick);
endmodule

// File: rtl/wsync_bridge.sv
module wsync_bridge
  import wsync_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SYNC_STG = 2
) (
  input  logic              busClk,
  input  logic              busRstN,
  input  logic              coreClk,
  input  logic              coreRstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [2:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busReady,
  output logic              syncBusy,
  output logic              irq,
  output logic [DATA_W-1:0] coreCtrl,
  output logic              coreKick,
  output logic [DATA_W-1:0] coreKickVal
);
  xferStrobeT        strobe;
  logic              ackDone;
  logic [DATA_W-1:0] ctrlShadow;

  wsync_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .busClk, .busRstN, .busSel, .busWrite, .busAddr, .busWdata,
    .ctrlShadow, .ackDone, .strobe, .busRdata, .busReady, .syncBusy, .irq);

  wsync_dpath #(.DATA_W(DATA_W), .SYNC_STG(SYNC_STG)) dpath_i (
    .busClk, .busRstN, .coreClk, .coreRstN, .strobe, .busyIn(syncBusy),
    .busWdata, .ackDone, .ctrlShadow, .coreCtrl, .coreKick, .coreKickVal);
endmodule

// File: tb/wsync_bridge_tb.sv
module wsync_bridge_tb_top;
  localparam int DW = 8;

  logic busClk = 0, coreClk = 0, busRstN = 0, coreRstN = 0;
  logic busSel = 0, busWrite = 0;
  logic [2:0] busAddr = '0;
  logic [DW-1:0] busWdata = '0, busRdata, coreCtrl, coreKickVal;
  logic busReady, syncBusy, irq, coreKick;

  int checks = 0, errors = 0, kickCount = 0, logN = 0;
  logic [DW-1:0] logArr [16];
  logic [DW-1:0] lastCtrl = '0;
  bit done = 0;

  always #2.5 busClk = ~busClk;
  always #6.5 coreClk = ~coreClk;

  wsync_bridge #(.DATA_W(DW)) dut_i (
    .busClk, .busRstN, .coreClk, .coreRstN, .busSel, .busWrite, .busAddr,
    .busWdata, .busRdata, .busReady, .syncBusy, .irq, .coreCtrl, .coreKick,
    .coreKickVal);

  // core-domain observer at the ports
  always @(posedge coreClk) begin
    if (coreKick) kickCount++;
    if (coreCtrl !== lastCtrl) begin
      if (logN < 16) logArr[logN] = coreCtrl;
      logN++;
      lastCtrl = coreCtrl;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [2:0] a, input logic [DW-1:0] d, output int stalls);
    @(negedge busClk);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d; stalls = 0;
    #1;
    while (!busReady) begin
      @(negedge busClk); stalls++; #1;
    end
    @(posedge busClk); #1;
    busSel = 0; busWrite = 0;
  endtask

  task automatic busRd(input logic [2:0] a, output logic [DW-1:0] d, output logic rdy);
    @(negedge busClk);
    busSel = 1; busWrite = 0; busAddr = a;
    #1; d = busRdata; rdy = busReady;
    @(posedge busClk); #1;
    busSel = 0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 200 && syncBusy; i++) @(negedge busClk);
    repeat (2) @(negedge coreClk);
  endtask

  task automatic t_reset();
    chk("R1 busy", syncBusy, 0);
    chk("R1 irq", irq, 0);
    chk("R1 ready", busReady, 1);
    chk("R1 coreCtrl", coreCtrl, 0);
    chk("R1 coreKick", coreKick, 0);
  endtask

  task automatic t_ctrlWrite();
    int s; logic [DW-1:0] d; logic r;
    busWr(3'd0, 8'hA5, s);
    chk("R4 busy after accept", syncBusy, 1);
    busRd(3'd2, d, r);
    chk("R4 status bit", d[0], 1);
    waitIdle();
    chk("R4 busy cleared", syncBusy, 0);
    chk("R2 coreCtrl", coreCtrl, 8'hA5);
    busRd(3'd0, d, r);
    chk("R2 readback", d, 8'hA5);
    busRd(3'd3, d, r);
    chk("R5 flag set", d[0], 1);
    chk("R7 irq off without enable", irq, 0);
  endtask

  task automatic t_irq();
    int s; logic [DW-1:0] d; logic r;
    busWr(3'd4, 8'h00, s);
    chk("R8 zero set ignored", irq, 0);
    busWr(3'd4, 8'h01, s);
    chk("R7 irq on", irq, 1);
    busRd(3'd5, d, r);
    chk("R8 enable readback", d[0], 1);
    busWr(3'd5, 8'h00, s);
    chk("R8 zero clear ignored", irq, 1);
    busWr(3'd5, 8'h01, s);
    chk("R8 enable cleared", irq, 0);
    busWr(3'd4, 8'h01, s);
    busWr(3'd3, 8'h00, s);
    chk("R9 zero write keeps flag", irq, 1);
    busWr(3'd3, 8'h01, s);
    chk("R9 flag cleared", irq, 0);
    busRd(3'd3, d, r);
    chk("R9 flag reads 0", d[0], 0);
  endtask

  task automatic t_kick();
    int s; int k0;
    k0 = kickCount;
    busWr(3'd1, 8'h5A, s);
    waitIdle();
    chk("R3 one pulse", kickCount - k0, 1);
    chk("R3 kick value", coreKickVal, 8'h5A);
    chk("R3 ctrl unchanged", coreCtrl, 8'hA5);
    chk("R7 irq on completion", irq, 1);
  endtask

  task automatic t_stall();
    int s1, s2, n0; logic [DW-1:0] d; logic r;
    busWr(3'd3, 8'h01, s1);
    n0 = logN;
    busWr(3'd0, 8'h11, s1);
    busWr(3'd0, 8'h22, s2);
    chk("R6 first not stalled", s1, 0);
    chk("R6 second stalled", s2 > 0, 1);
    waitIdle();
    chk("R6 change count", logN - n0, 2);
    if (logN - n0 == 2) begin
      chk("R6 first value", logArr[n0], 8'h11);
      chk("R6 second value", logArr[n0+1], 8'h22);
    end
    chk("R6 final", coreCtrl, 8'h22);
    busRd(3'd0, d, r);
    chk("R2 readback after stall", d, 8'h22);
  endtask

  task automatic t_unsync();
    int s; logic [DW-1:0] d; logic r;
    busWr(3'd5, 8'h01, s);
    busWr(3'd0, 8'h33, s);
    busRd(3'd2, d, r);
    chk("R10 read ready while busy", r, 1);
    chk("R10 status busy", d[0], 1);
    busWr(3'd4, 8'h01, s);
    chk("R10 write no stall", s, 0);
    waitIdle();
    chk("R2 coreCtrl 33", coreCtrl, 8'h33);
  endtask

  initial begin
    #(400_000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge busClk);
    #1; t_reset();
    busRstN = 1; coreRstN = 1;
    repeat (3) @(posedge coreClk);
    t_ctrlWrite();
    t_irq();
    t_kick();
    t_stall();
    t_unsync();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule